// File: doc/BRIEF.md
# Input Capture Measurement Timer

This block is one 24-bit timer channel that times an external input. In input-period mode it counts timer ticks between two successive edges of the same polarity. In pulse-width mode it counts ticks only while the input is at its active level. Each finished measurement is copied into a capture register and raises a completion flag. The flag can drive an interrupt request.

The input pin passes through a synchronizer. A single invert select picks the active edge for both modes. A restart select decides what happens after each capture. When it is set, the counter reloads from the load register. When it is clear, the counter keeps its value: in period mode it keeps counting, and in pulse-width mode it adds the next width to the total. The counter advances only on cycles where the tick input is high. That tick is a divided or prescaled clock enable made outside the block.

Top module: `capture_timer`

## Requirements
- R1: Mode code 4'b0101 selects input-period measurement and 4'b0100 selects pulse-width measurement. With any other code, no edge captures and the counter does not move.
- R2: The pin is sampled by two flops and then compared with one more delayed sample. A pin change driven before clock edge k therefore takes effect at clock edge k+2.
- R3: In period mode with `inv`=0, rising pin edges are active. With `inv`=1, falling pin edges are active.
- R4: The first active edge after enabling loads the counter from `load_val`. It does not capture and leaves `done` unchanged.
- R5: Each later measuring edge copies the counter into `cap_val` and sets `done`. `cap_val` resets to 0 and changes at no other time.
- R6: With `restart`=1, a capture also reloads the counter from `load_val`. With `restart`=0, the counter keeps its value, so in period mode counting goes on across captures.
- R7: In pulse-width mode with `inv`=0, a rising pin edge starts counting and a falling edge stops it and captures. With `inv`=1, the roles swap.
- R8: In pulse-width mode with `restart`=0, the next start edge resumes from the held count, so successive widths add up.
- R9: While measuring, the counter increases by exactly one for each cycle with `tick`=1. It does not increase in a cycle where an edge loads, captures or resumes.
- R10: `ovf` sets when the counter steps from all ones to zero.
- R11: `done` and `ovf` reset to 0 and clear when 1 is written to `clr_done` or `clr_ovf`. A new set event in the same cycle wins over the clear.
- R12: `irq` is high exactly when `done` and `irq_en` are both 1.
- R13: With `en`=0 the counter holds, the edge tracking returns to waiting for a first edge, and `cap_val` is retained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Counter advance enable |
| pin_in | input | 1 | Asynchronous measured input |
| en | input | 1 | Channel enable |
| mode | input | 4 | Mode code (0101 period, 0100 pulse width) |
| inv | input | 1 | Active edge select |
| restart | input | 1 | Reload after capture |
| irq_en | input | 1 | Interrupt enable |
| load_val | input | 24 | Load register value |
| clr_done | input | 1 | Write one to clear `done` |
| clr_ovf | input | 1 | Write one to clear `ovf` |
| cap_val | output | 24 | Capture register |
| done | output | 1 | Measurement complete flag |
| ovf | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the exact cycle of capture. A design with one synchronizer stage too many or too few would raise `done` one cycle early or late and would count one tick too many or too few. Load values just below the top of the range force a wrap. A design that misses the wrap, or flags it one step off, would show a wrong `ovf`. Runs with restart clear check both period carry-over and width accumulation, which a design that always reloads would get wrong. Runs with the channel disabled or given an unused mode code must leave `cap_val` and `done` unchanged, and the first edge after enabling must only load.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam logic [3:0] MODE_PULSE  = 4'b0100;
  localparam logic [3:0] MODE_PERIOD = 4'b0101;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } ct_state_t;

  // active edge picker shared by both measurement modes
  function automatic logic pick_edge(input logic rise, input logic fall, input logic sel_fall);
    return sel_fall ? fall : rise;
  endfunction
endpackage

// File: rtl/ct_sync.sv
module ct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int LAST = STAGES;
  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= pin;
  end

  generate
    for (genvar i = 1; i <= LAST; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign rise = chain[LAST-1] & ~chain[LAST];
  assign fall = ~chain[LAST-1] & chain[LAST];
endmodule

// File: rtl/ct_ctrl.sv
module ct_ctrl
  import ct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [3:0] mode,
  input  logic       inv,
  input  logic       rise,
  input  logic       fall,
  output logic       load_evt,
  output logic       cap_evt,
  output logic       busy,
  output logic       counting
);
  ct_state_t st, st_nx;
  logic is_per, is_pw, act, deact, per_cap, pw_cap, resume;

  assign is_per = (mode == MODE_PERIOD);
  assign is_pw  = (mode == MODE_PULSE);
  assign act    = pick_edge(rise, fall, inv);
  assign deact  = pick_edge(fall, rise, inv);

  assign load_evt = en && (is_per || is_pw) && (st == ST_WAIT) && act;
  assign per_cap  = en && is_per && (st == ST_RUN) && act;
  assign pw_cap   = en && is_pw && (st == ST_RUN) && deact;
  assign resume   = en && is_pw && (st == ST_HOLD) && act;
  assign cap_evt  = per_cap || pw_cap;
  assign busy     = load_evt || cap_evt || resume;
  assign counting = en && (is_per || is_pw) && (st == ST_RUN);

  always_comb begin
    st_nx = st;
    if (!en || !(is_per || is_pw)) st_nx = ST_WAIT;
    else if (load_evt)             st_nx = ST_RUN;
    else if (pw_cap)               st_nx = ST_HOLD;
    else if (resume)               st_nx = ST_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_WAIT;
    else        st <= st_nx;
  end
endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic         step,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  // returns {carry, sum}
  function automatic logic [W:0] next_count(input logic [W-1:0] v);
    return {1'b0, v} + {{W{1'b0}}, 1'b1};
  endfunction

  logic [W:0] nxt;
  assign nxt  = next_count(cnt);
  assign wrap = step && nxt[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (reload) cnt <= load_val;
    else if (step)   cnt <= nxt[W-1:0];
  end

  // keeps ALL_ONES meaningful for readers; equals carry condition
  logic unused_ok;
  assign unused_ok = (cnt == ALL_ONES) ^ nxt[W];
endmodule

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int CNT_W = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pin_in,
  input  logic             en,
  input  logic [3:0]       mode,
  input  logic             inv,
  input  logic             restart,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clr_done,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] cap_val,
  output logic             done,
  output logic             ovf,
  output logic             irq
);
  logic rise, fall;
  logic load_evt, cap_evt, busy, counting;
  logic adv_evt, wrap_evt, reload;
  logic [CNT_W-1:0] cnt;

  ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .rise(rise), .fall(fall)
  );

  ct_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .inv(inv),
    .rise(rise), .fall(fall), .load_evt(load_evt), .cap_evt(cap_evt),
    .busy(busy), .counting(counting)
  );

  assign adv_evt = counting && tick && !busy;
  assign reload  = load_evt || (cap_evt && restart);

  ct_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .reload(reload), .step(adv_evt),
    .load_val(load_val), .cnt(cnt), .wrap(wrap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val <= '0;
      done    <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (cap_evt) cap_val <= cnt;
      if (cap_evt)       done <= 1'b1;
      else if (clr_done) done <= 1'b0;
      if (wrap_evt)      ovf <= 1'b1;
      else if (clr_ovf)  ovf <= 1'b0;
    end
  end

  assign irq = done && irq_en;
endmodule

// File: rtl/ct_checker.sv
module ct_checker
  import ct_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [3:0]       mode,
  input logic             irq_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cap_val,
  input logic             done,
  input logic             ovf,
  input logic             irq,
  input logic             cap_evt,
  input logic             wrap_evt,
  input logic             adv_evt
);
  assert_other_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_PERIOD && mode != MODE_PULSE) |-> (!cap_evt && !adv_evt));

  assert_cap_only_on_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_val));

  assert_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> (cnt == $past(cnt) + 1'b1));

  assert_ovf_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(wrap_evt));

  assert_done_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cap_evt));

  assert_irq_follow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && irq_en) |=> (irq || !irq_en));

  assert_hold_disabled_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt) && $stable(cap_val)));
endmodule

bind capture_timer ct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .irq_en(irq_en),
  .cnt(cnt), .cap_val(cap_val), .done(done), .ovf(ovf), .irq(irq),
  .cap_evt(cap_evt), .wrap_evt(wrap_evt), .adv_evt(adv_evt)
);

// File: tb/capture_timer_test.sv
module capture_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, pin_in = 1'b0, en = 1'b0, inv = 1'b0, restart = 1'b0, irq_en = 1'b0;
  logic [3:0] mode = 4'd0;
  logic [W-1:0] load_val = '0;
  logic clr_done = 1'b0, clr_ovf = 1'b0;
  logic [W-1:0] cap_val;
  logic done, ovf, irq;

  int total = 0, bad = 0;
  bit hist [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  capture_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pin_in(pin_in), .en(en), .mode(mode),
    .inv(inv), .restart(restart), .irq_en(irq_en), .load_val(load_val),
    .clr_done(clr_done), .clr_ovf(clr_ovf), .cap_val(cap_val), .done(done),
    .ovf(ovf), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ticks_in(input int a, input int b);
    int n = 0;
    for (int i = a; i <= b; i++) n += hist[i] ? 1 : 0;
    return n;
  endfunction

  // quiet the channel: disable, clear flags, settle the synchronizer at baseline
  task automatic settle(input bit iv);
    en = 1'b0; clr_done = 1'b1; clr_ovf = 1'b1; pin_in = iv; tick = 1'b0;
    repeat (4) @(negedge clk);
    clr_done = 1'b0; clr_ovf = 1'b0;
  endtask

  // period: active-level blips at t0,t1,t2 ; pulse: active [t0,t1) and [t2,t3)
  task automatic run_case(input bit per, input bit iv, input bit rs, input bit ie,
                          input logic [W-1:0] L, input int g1, input int g2, input int g3,
                          input bit full);
    int t0, t1, t2, t3, c1, c2, sa, sb;
    logic [W:0] s1, s2;
    logic [W-1:0] base;
    bit lvl;
    t0 = 4; t1 = t0 + g1; t2 = t1 + g2; t3 = t2 + g3;
    c1 = t1 + 2;
    c2 = per ? t2 + 2 : t3 + 2;
    settle(iv);
    mode = per ? 4'b0101 : 4'b0100; inv = iv; restart = rs; irq_en = ie; load_val = L;
    en = 1'b1;
    s1 = '0;
    for (int k = 0; k <= c2; k++) begin
      if (per) lvl = (k >= t0 && k < t0+2) || (k >= t1 && k < t1+2) || (k >= t2 && k < t2+2);
      else     lvl = (k >= t0 && k < t1) || (k >= t2 && k < t3);
      pin_in = lvl ^ iv;
      tick = full ? 1'b1 : 1'($urandom % 2);
      hist[k] = tick;
      clr_done = (k == c1 + 1);
      @(negedge clk);
      if (k == c1 - 1) chk("R2 done not yet set", 32'(done), 32'd0);
      if (k == c1) begin
        s1 = {1'b0, L} + (W+1)'(ticks_in(t0 + 3, t1 + 1));
        chk(per ? "R3/R5 period capture" : "R7 pulse capture", 32'(cap_val), 32'(s1[W-1:0]));
        chk("R5 done set", 32'(done), 32'd1);
        chk("R12 irq", 32'(irq), 32'(ie));
        chk("R10 ovf first", 32'(ovf), 32'(s1[W]));
      end
      if (k == c1 + 1) chk("R11 done cleared", 32'(done), 32'd0);
      if (k == c2) begin
        sa = per ? t1 : t2; sb = per ? t2 : t3;
        base = rs ? L : s1[W-1:0];
        s2 = {1'b0, base} + (W+1)'(ticks_in(sa + 3, sb + 1));
        chk(rs ? "R6 reload capture" : "R6/R8 carry-on capture", 32'(cap_val), 32'(s2[W-1:0]));
        chk("R9 done second", 32'(done), 32'd1);
        chk("R10 ovf sticky", 32'(ovf), 32'(s1[W] | s2[W]));
      end
    end
    clr_done = 1'b0;
  endtask

  task automatic blip(input bit iv, input int n);
    for (int i = 0; i < n; i++) begin
      pin_in = ~iv; repeat (3) @(negedge clk);
      pin_in = iv;  repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R5 reset cap", 32'(cap_val), 32'd0);
    chk("R11 reset done", 32'(done), 32'd0);
    chk("R11 reset ovf", 32'(ovf), 32'd0);
    chk("R12 reset irq", 32'(irq), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_case(1'b0, 1'b0, 1'b0, 1'b1, 24'hFFFFFD, 5, 4, 3, 1'b1); // R10 wrap in pulse
    run_case(1'b1, 1'b1, 1'b0, 1'b0, 24'h000010, 6, 9, 0, 1'b1); // R3 falling, carry on
    run_case(1'b0, 1'b1, 1'b0, 1'b1, 24'h000100, 4, 5, 7, 1'b0); // R7/R8 inverted accumulate
    run_case(1'b1, 1'b0, 1'b1, 1'b1, 24'hFFFFF0, 12, 20, 0, 1'b1); // R6 reload near top

    // R13: disabled channel ignores edges and keeps capture
    held = cap_val;
    settle(1'b0);
    mode = 4'b0101; inv = 1'b0;
    blip(1'b0, 3);
    chk("R13 cap kept while disabled", 32'(cap_val), 32'(held));
    chk("R13 no done while disabled", 32'(done), 32'd0);
    // R4: after enabling, a single active edge only loads
    en = 1'b1;
    blip(1'b0, 1);
    chk("R4 first edge no capture", 32'(done), 32'd0);
    chk("R4 cap unchanged", 32'(cap_val), 32'(held));
    // R1: unused mode code ignores edges
    settle(1'b0);
    mode = 4'b0000; en = 1'b1;
    blip(1'b0, 3);
    chk("R1 unused mode no done", 32'(done), 32'd0);
    chk("R1 unused mode cap kept", 32'(cap_val), 32'(held));

    // constrained random
    for (int r = 0; r < 24; r++) begin
      bit per, iv, rs, ie, full;
      logic [W-1:0] L;
      per = 1'($urandom % 2); iv = 1'($urandom % 2); rs = 1'($urandom % 2);
      ie = 1'($urandom % 2); full = 1'($urandom % 2);
      L = ($urandom % 4 == 0) ? (24'hFFFFFF - 24'($urandom % 24)) : 24'($urandom);
      run_case(per, iv, rs, ie, L, 4 + int'($urandom % 37), 4 + int'($urandom % 37),
               2 + int'($urandom % 37), full);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule